// File: doc/BRIEF.md
# I2C Slave Byte Transfer Engine

This block moves data bytes on the target side of a two-wire serial bus once an external address comparator has matched. In a read the block shifts a transmit byte out on the data line. In a write it gathers a byte from the data line. It answers each received byte with an acknowledge or a not-acknowledge. It can hold the clock line low so that software has time to supply or collect data. Both bus lines are open-drain, so the block only produces pull-low enables.

The address comparator starts a transfer with a one-cycle `xfer_start` pulse while the clock line is low, right after the address acknowledge. `xfer_rd` gives the direction. A `bus_stop` pulse marks a STOP or repeated START and sends the block back to idle. Software works through write strobes:
- a transmit-buffer write,
- a release command,
- a receive-buffer read,
- an overflow clear.

One interrupt pulse marks the end of every byte.

Top module: `i2cs_data_engine`

## Requirements
- R1: Incoming data bits are taken at rising clock-line edges, most significant bit first. At the eighth falling edge, if `rx_full` is clear, the byte is copied to `rx_data` and `rx_full` becomes 1. A `rx_rd` pulse clears `rx_full`.
- R2: A byte that is accepted while `rx_ovf` is 0 is acknowledged: the data line is pulled low during the ninth clock.
- R3: When a byte completes while `rx_full` is 1, `rx_data` keeps the older byte, `rx_ovf` becomes 1, no acknowledge is given, and the interrupt still fires.
- R4: `rx_ovf` stays 1 until `ovf_clr` is pulsed. While it is 1, a byte that completes with `rx_full` clear is still loaded, but it is not acknowledged.
- R5: A read start with an empty transmit buffer clears `scl_rel` and holds the clock line low. A `tx_wr` sets `tx_full` and `scl_rel`, which frees the clock line.
- R6: Transmit bits leave most significant bit first. The data-line enable changes only while the clock line is low.
- R7: In transmit, at the ninth falling edge, an acknowledge from the controller with `tx_full` clear clears `scl_rel` and holds the clock line low. This happens whatever the value of `stretch_en`.
- R8: In receive, with `stretch_en` at 1, at the ninth falling edge, an acknowledged byte with `rx_full` set clears `scl_rel` and holds the clock line low. With `stretch_en` at 0 the clock line is never held in receive.
- R9: A transmit buffer filled, or a receive buffer read, before the ninth falling edge leaves `scl_rel` set, so the clock line is not held. A buffer filled early is sent as the next byte.
- R10: A `rel_set` pulse sets `scl_rel` and frees a held clock line at any time.
- R11: `irq` is a one-cycle pulse after every ninth falling edge, in both directions. In transmit this includes a not-acknowledge from the controller.
- R12: After a not-acknowledge in transmit, the block leaves the data line free until `bus_stop`, even if the transmit buffer holds data. That data is sent by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized clock-line level |
| sda_i | input | 1 | Synchronized data-line level |
| xfer_start | input | 1 | Address matched, begin a transfer |
| xfer_rd | input | 1 | Direction with `xfer_start`: 1 = block transmits |
| bus_stop | input | 1 | STOP or repeated START seen |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DW | Transmit buffer write data |
| rel_set | input | 1 | Set the clock release bit |
| rx_rd | input | 1 | Receive buffer read strobe |
| ovf_clr | input | 1 | Clear the overflow flag |
| stretch_en | input | 1 | Allow clock holding in receive |
| sda_oe | output | 1 | Pull the data line low |
| scl_oe | output | 1 | Pull the clock line low |
| rx_data | output | DW | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| tx_full | output | 1 | Transmit buffer holds an unsent byte |
| rx_ovf | output | 1 | Receive overflow, sticky |
| scl_rel | output | 1 | Clock release bit |
| irq | output | 1 | End-of-byte interrupt pulse |

## Verification
The bench models a controller that drives both lines wired-AND with the block's enables.

- **Receive path:** every one of the 256 byte values is sent, which catches any bit-order or shift error.
- **Transmit path:** every one of the 256 byte values is returned, which catches the same errors. Each transmit byte starts from a held clock, which confirms the forced hold that happens regardless of the enable.
- **Receive buffer states:** the buffer-full and overflow patterns separate dropping a byte, loading it without an acknowledge, and normal acceptance.
- **Hold and release:** early buffer fills and reads, explicit release, and a not-acknowledge from the controller show when the clock is held, when it is freed, and when the block stays silent.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_TXLD,
    ST_TX,
    ST_TXW
  } xfer_st_t;
endpackage

// File: rtl/i2cs_edge.sv
module i2cs_edge (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= line;
  end

  assign rise = line & ~prev;
  assign fall = ~line & prev;
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [DW-1:0] din,
  input  logic          rd,
  input  logic          ovf_clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (commit && !full) begin
        data <= din;
        full <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
      if (commit && full) ovf <= 1'b1;
      else if (ovf_clr)   ovf <= 1'b0;
    end
  end

  // R3: a byte arriving on a full buffer is dropped and flagged
  p_overflow_keep_r3: assert property (@(posedge clk) disable iff (rst)
    commit && full |=> ovf && $stable(data));
  // R1: a byte arriving on an empty buffer is kept
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    commit && !full |=> full && data == $past(din));
endmodule

// File: rtl/i2cs_txbuf.sv
module i2cs_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      if (wr)        full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end

  // R5: loading the shifter empties the buffer
  p_take_empties_r5: assert property (@(posedge clk) disable iff (rst)
    take && !wr |=> !full);
endmodule

// File: rtl/i2cs_data_engine.sv
module i2cs_data_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          xfer_start,
  input  logic          xfer_rd,
  input  logic          bus_stop,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rel_set,
  input  logic          rx_rd,
  input  logic          ovf_clr,
  input  logic          stretch_en,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          tx_full,
  output logic          rx_ovf,
  output logic          scl_rel,
  output logic          irq
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);

  xfer_st_t      st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr;
  logic [DW-1:0] tx_buf;
  logic          rise, fall;
  logic          ack_low, ack_drive;
  logic          byte_done, nine_fall, take, auto_clr;

  i2cs_edge u_scl_edge (
    .clk (clk), .rst (rst), .line (scl_i), .rise (rise), .fall (fall)
  );

  assign byte_done = fall && st == ST_RX && cnt == LAST_BIT;
  assign nine_fall = fall && cnt == ACK_SLOT && (st == ST_RX || st == ST_TX);
  assign take      = st == ST_TXLD && scl_rel && !bus_stop;
  assign auto_clr  = (nine_fall && st == ST_TX && ack_low && !tx_full)
                   || (nine_fall && st == ST_RX && stretch_en && ack_low && rx_full)
                   || (xfer_start && st == ST_IDLE && xfer_rd && !tx_full);

  i2cs_rxbuf #(.DW(DW)) u_rxbuf (
    .clk (clk), .rst (rst), .commit (byte_done), .din (sr), .rd (rx_rd),
    .ovf_clr (ovf_clr), .data (rx_data), .full (rx_full), .ovf (rx_ovf)
  );

  i2cs_txbuf #(.DW(DW)) u_txbuf (
    .clk (clk), .rst (rst), .wr (tx_wr), .wdata (tx_wdata), .take (take),
    .data (tx_buf), .full (tx_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sr        <= '0;
      ack_low   <= 1'b0;
      ack_drive <= 1'b0;
    end else if (bus_stop) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (xfer_start) begin
          st  <= xfer_rd ? ST_TXLD : ST_RX;
          cnt <= '0;
        end
        ST_RX: begin
          if (rise && cnt < ACK_SLOT) sr <= {sr[DW-2:0], sda_i};
          if (rise && cnt == ACK_SLOT) ack_low <= !sda_i;
          if (fall) cnt <= (cnt == ACK_SLOT) ? '0 : cnt + 1'b1;
          if (byte_done) ack_drive <= !rx_full && !rx_ovf;
        end
        ST_TXLD: if (scl_rel) begin
          sr  <= tx_buf;
          st  <= ST_TX;
          cnt <= '0;
        end
        ST_TX: begin
          if (rise && cnt == ACK_SLOT) ack_low <= !sda_i;
          if (fall) begin
            if (cnt == ACK_SLOT) begin
              cnt <= '0;
              st  <= ack_low ? ST_TXLD : ST_TXW;
            end else begin
              cnt <= cnt + 1'b1;
              sr  <= sr << 1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   scl_rel <= 1'b1;
    else if (tx_wr || rel_set) scl_rel <= 1'b1;
    else if (auto_clr)         scl_rel <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      irq    <= nine_fall;
      sda_oe <= (st == ST_TX && cnt < ACK_SLOT && !sr[DW-1])
             || (st == ST_RX && cnt == ACK_SLOT && ack_drive);
      scl_oe <= (st == ST_RX || st == ST_TXLD) && !scl_rel;
    end
  end

  // R5: a buffer write releases the clock and marks the buffer full
  p_rel_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> scl_rel && tx_full);
  // R10: the clock is held only while the release bit is clear
  p_hold_needs_clear_r10: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !$past(scl_rel));
  // R11: the interrupt lasts one cycle
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R12: silent on the data line after a not-acknowledge
  p_nack_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    st == ST_TXW && $past(st) == ST_TXW |-> !sda_oe);
  // R2: in receive the data line is pulled only in the acknowledge slot
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (rst)
    sda_oe && st == ST_RX |-> $past(cnt) == ACK_SLOT);
endmodule

// File: tb/i2cs_data_engine_bench.sv
module i2cs_data_engine_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic xfer_start = 0, xfer_rd = 0, bus_stop = 0, tx_wr = 0, rel_set = 0;
  logic rx_rd = 0, ovf_clr = 0, stretch_en = 0;
  logic [DW-1:0] tx_wdata = '0;
  logic sda_oe, scl_oe, rx_full, tx_full, rx_ovf, scl_rel, irq;
  logic [DW-1:0] rx_data;
  logic scl_line, sda_line;
  int nchk = 0, nerr = 0, irq_cnt = 0, sda_glitch = 0;
  logic scl_d = 1'b1, sda_d = 1'b0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2cs_data_engine #(.DW(DW)) u_i2cs_data_engine (
    .clk (clk), .rst (rst), .scl_i (scl_line), .sda_i (sda_line),
    .xfer_start (xfer_start), .xfer_rd (xfer_rd), .bus_stop (bus_stop),
    .tx_wr (tx_wr), .tx_wdata (tx_wdata), .rel_set (rel_set), .rx_rd (rx_rd),
    .ovf_clr (ovf_clr), .stretch_en (stretch_en), .sda_oe (sda_oe),
    .scl_oe (scl_oe), .rx_data (rx_data), .rx_full (rx_full),
    .tx_full (tx_full), .rx_ovf (rx_ovf), .scl_rel (scl_rel), .irq (irq)
  );

  always @(posedge clk) begin
    if (!rst && irq) irq_cnt++;
    if (!rst && scl_line && scl_d && sda_oe != sda_d) sda_glitch++;
    scl_d <= scl_line;
    sda_d <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual running expected finished");
    finish_sim();
  end

  task automatic clk_bit(input logic b, output logic r);
    @(negedge clk) sda_m = b;
    repeat (4) @(negedge clk);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    repeat (4) @(negedge clk);
    r = sda_line;
    scl_m = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_rxrd();
    @(negedge clk) rx_rd = 1'b1;
    @(negedge clk) rx_rd = 1'b0;
  endtask

  task automatic write_tx(input logic [DW-1:0] d);
    @(negedge clk) begin tx_wr = 1'b1; tx_wdata = d; end
    @(negedge clk) tx_wr = 1'b0;
  endtask

  task automatic start_xfer(input logic rd);
    @(negedge clk) begin xfer_start = 1'b1; xfer_rd = rd; end
    @(negedge clk) xfer_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_bus();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] d, input logic early_rd, output logic ackbit);
    logic r;
    for (int i = DW - 1; i >= 0; i--) clk_bit(d[i], r);
    if (early_rd) pulse_rxrd();
    clk_bit(1'b1, ackbit);
  endtask

  task automatic recv_byte(input logic mack, input logic early_wr, input logic [DW-1:0] wd,
                           output logic [DW-1:0] d);
    logic r;
    for (int i = DW - 1; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    if (early_wr) write_tx(wd);
    clk_bit(mack, r);
  endtask

  initial begin
    logic a;
    logic [DW-1:0] got;
    int ic;
    scl_m = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset", {rx_full, tx_full, rx_ovf, scl_rel, sda_oe, scl_oe, irq}, 7'b0001000);

    // R1 R2 R11: receive sweep over all byte values
    start_xfer(1'b0);
    for (int v = 0; v < 256; v++) begin
      ic = irq_cnt;
      send_byte(DW'(v), 1'b0, a);
      chk("R2 ack", a, 0);
      chk("R1 data", rx_data, v);
      chk("R1 full", rx_full, 1);
      chk("R11 irq", irq_cnt - ic, 1);
      pulse_rxrd();
      chk("R1 read clears", rx_full, 0);
    end

    // R8 disabled: buffer full but no hold
    send_byte(8'hA5, 1'b0, a);
    chk("R8 no hold when disabled", {scl_rel, scl_oe}, 2'b10);
    // R3 overflow
    ic = irq_cnt;
    send_byte(8'h3C, 1'b0, a);
    chk("R3 nack", a, 1);
    chk("R3 data kept", rx_data, 8'hA5);
    chk("R3 ovf", rx_ovf, 1);
    chk("R3 irq", irq_cnt - ic, 1);
    // R4 sticky overflow: loads but no ack
    pulse_rxrd();
    send_byte(8'h5A, 1'b0, a);
    chk("R4 load", {rx_full, rx_data}, {1'b1, 8'h5A});
    chk("R4 nack", a, 1);
    chk("R4 ovf sticky", rx_ovf, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R4 ovf cleared", rx_ovf, 0);
    pulse_rxrd();
    send_byte(8'hC3, 1'b0, a);
    chk("R4 ack again", a, 0);
    pulse_rxrd();

    // R8 enabled hold, R10 release
    stretch_en = 1'b1;
    send_byte(8'h81, 1'b0, a);
    chk("R8 hold", {scl_rel, scl_oe}, 2'b01);
    pulse_rxrd();
    @(negedge clk) rel_set = 1'b1;
    @(negedge clk) rel_set = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 release", {scl_rel, scl_oe}, 2'b10);
    // R9 early read avoids hold
    send_byte(8'h7E, 1'b1, a);
    chk("R9 no hold after early read", {scl_rel, scl_oe}, 2'b10);
    chk("R9 data", rx_data, 8'h7E);
    pulse_rxrd();
    stop_bus();
    stretch_en = 1'b0;

    // R5 R6 R7: transmit sweep, each byte from a held clock
    start_xfer(1'b1);
    for (int v = 0; v < 256; v++) begin
      chk("R5 R7 held before byte", {scl_rel, scl_oe}, 2'b01);
      write_tx(DW'(v));
      chk("R5 write sets", {tx_full, scl_rel}, 2'b11);
      ic = irq_cnt;
      recv_byte(1'b0, 1'b0, '0, got);
      chk("R6 tx data", got, v);
      chk("R11 tx irq", irq_cnt - ic, 1);
    end
    repeat (2) @(negedge clk);
    chk("R7 hold after ack", {scl_rel, scl_oe}, 2'b01);
    // R9 early fill
    write_tx(8'h96);
    recv_byte(1'b0, 1'b1, 8'h4B, got);
    chk("R9 first byte", got, 8'h96);
    repeat (2) @(negedge clk);
    chk("R9 no hold after early fill", {scl_rel, scl_oe}, 2'b10);
    recv_byte(1'b0, 1'b0, '0, got);
    chk("R9 queued byte sent", got, 8'h4B);
    // R11 R12 controller nack
    write_tx(8'hE1);
    ic = irq_cnt;
    recv_byte(1'b1, 1'b0, '0, got);
    chk("R6 last byte", got, 8'hE1);
    chk("R11 irq on nack", irq_cnt - ic, 1);
    write_tx(8'h00);
    recv_byte(1'b1, 1'b0, '0, got);
    chk("R12 line free after nack", got, 8'hFF);
    chk("R12 buffer untouched", tx_full, 1);
    stop_bus();
    start_xfer(1'b1);
    chk("R9 no hold with full buffer", {scl_rel, scl_oe}, 2'b10);
    recv_byte(1'b1, 1'b0, '0, got);
    chk("R12 pending byte sent next read", got, 8'h00);
    stop_bus();
    chk("R6 data stable while clock high", sda_glitch, 0);
    finish_sim();
  end
endmodule